// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block fetches instruction bytes ahead of the execution side and keeps them in a small byte-wide first-in-first-out queue. Each fetch address is a 20-bit physical address formed from a 16-bit code segment and a 16-bit offset. Requests go out on a simple request/acknowledge memory bus. The bus is 16 bits wide by default and can be set to 8 bits with a parameter. The queue is six bytes deep on the wide bus and four bytes deep on the narrow one.

The execution side takes one byte at a time from a valid/pop port. While it is busy, the unit keeps fetching until the queue is full, so fetching overlaps execution. On a taken branch the execution side pulses a redirect with a new segment and offset. This empties the queue and restarts fetching at the new location. Any fetch still on the bus at that moment completes, and its data is thrown away.

Bus protocol: `mem_req_o` is held high with `mem_addr_o` stable until a one-cycle `mem_ack_i`. `mem_rdata_i` is valid in that cycle. On the wide bus, the byte at the even address is in bits 7:0 and the byte at the odd address is in bits 15:8.

Top module: `prefetch_queue`

## Requirements
- R1: The fetch address is (segment × 16 + offset) modulo 2^20. The first request after a redirect carries the new segment and offset.
- R2: The queue holds 6 bytes with a 16-bit bus and 4 bytes with an 8-bit bus, and never holds more.
- R3: A fetch starts only when at least 2 bytes (16-bit bus) or 1 byte (8-bit bus) of the queue are free. A full-width fetch from an odd start therefore leaves the 16-bit queue at 5 bytes with no request until one byte is popped.
- R4: After each accepted fetch the offset advances by the number of bytes taken. On the 16-bit bus, a fetch from an odd address takes only bits 15:8 (one byte), and later fetches are then at even addresses.
- R5: Bytes leave in fetch order, one per cycle when `q_pop_i` is high and `q_valid_o` is high. A pop and a push in the same cycle are both applied.
- R6: Without pops, fetching continues until the queue is full, then `mem_req_o` stays low.
- R7: A redirect empties the queue, so `q_valid_o` is low in the following cycle, and fetching restarts at the new address.
- R8: A redirect during an outstanding fetch keeps `mem_req_o` and `mem_addr_o` unchanged until the acknowledge. The returned data does not enter the queue.
- R9: With the queue empty, `q_valid_o` is low and a pop has no effect.
- R10: The offset wraps from FFFFh to 0000h while the segment stays unchanged.
- R11: While `rst` is high, `mem_req_o` and `q_valid_o` are low. After reset, the first fetch is at segment FFFFh, offset 0000h (physical FFFF0h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_i | input | 1 | Redirect pulse: empty the queue and refetch |
| redir_seg_i | input | 16 | New code segment on redirect |
| redir_off_i | input | 16 | New offset on redirect |
| mem_req_o | output | 1 | Fetch request, held until acknowledge |
| mem_addr_o | output | 20 | Physical byte address of the fetch |
| mem_ack_i | input | 1 | One-cycle acknowledge with data |
| mem_rdata_i | input | BUS_W | Fetched data |
| q_valid_o | output | 1 | Head byte available |
| q_byte_o | output | 8 | Head byte |
| q_pop_i | input | 1 | Consume head byte |

## Verification
The assertions assume the memory side keeps to the handshake. Acknowledge comes only while a request is high, at most one per request, and read data is meaningful only in the acknowledge cycle. The stimulus respects this with a responder that acknowledges a held request one cycle after seeing it. The responder drops its acknowledge before it answers again, and a stall switch lets a request stay pending. The execution side may pulse a redirect or pop in any cycle. Every pop is driven away from the clock edge.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // 20-bit physical byte address from segment and offset
  function automatic logic [19:0] phys_addr(input logic [15:0] seg,
                                            input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // queue depth tied to bus width
  function automatic int queue_depth(input int bus_w);
    return (bus_w == 16) ? 6 : 4;
  endfunction

endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [1:0]       push_n,
  input  logic [7:0]       push_d0,
  input  logic [7:0]       push_d1,
  input  logic             pop,
  output logic             valid,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, wr_p1, wr_p2, rd_p1;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_p1  = bump(wr_q);
    wr_p2  = bump(wr_p1);
    rd_p1  = bump(rd_q);
    pop_ok = pop && (cnt_q != '0);
  end

  // storage without reset so it maps onto plain memory cells
  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push_n != 2'd0) store[wr_q]  <= push_d0;
      if (push_n == 2'd2) store[wr_p1] <= push_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_ok) rd_q <= rd_p1;
      case (push_n)
        2'd1:    wr_q <= wr_p1;
        2'd2:    wr_q <= wr_p2;
        default: wr_q <= wr_q;
      endcase
      cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop_ok);
    end
  end

  always_comb begin
    valid = (cnt_q != '0);
    head  = store[rd_q];
    count = cnt_q;
    free  = CNT_W'(DEPTH) - cnt_q;
  end

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int          BUS_W   = 16,
  parameter int          CNT_W   = 3,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redir,
  input  logic [15:0]      new_seg,
  input  logic [15:0]      new_off,
  input  logic [CNT_W-1:0] free,
  input  logic             ack,
  input  logic [BUS_W-1:0] rdata,
  output logic             req,
  output logic [19:0]      addr,
  output logic [1:0]       push_n,
  output logic [7:0]       push_d0,
  output logic [7:0]       push_d1,
  output logic [15:0]      seg_o,
  output logic             drop_o
);
  localparam int               LANES = BUS_W / 8;
  localparam logic [CNT_W-1:0] NEED  = CNT_W'(LANES);

  logic        busy_q, drop_q;
  logic [15:0] seg_q, off_q;
  logic [19:0] addr_q;
  logic [1:0]  take_n;
  logic [7:0]  lane0, lane1;
  logic        accept;

  generate
    if (LANES == 2) begin : g_wide
      // odd start: only the upper lane belongs to the stream
      always_comb begin
        take_n = addr_q[0] ? 2'd1 : 2'd2;
        lane0  = addr_q[0] ? rdata[15:8] : rdata[7:0];
        lane1  = rdata[15:8];
      end
    end else begin : g_narrow
      always_comb begin
        take_n = 2'd1;
        lane0  = rdata[7:0];
        lane1  = 8'h00;
      end
    end
  endgenerate

  assign accept = busy_q && ack && !drop_q && !redir;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      seg_q  <= RST_SEG;
      off_q  <= RST_OFF;
      addr_q <= '0;
    end else begin
      if (busy_q && ack) begin
        busy_q <= 1'b0;
        drop_q <= 1'b0;
      end
      if (accept) off_q <= off_q + {14'd0, take_n};
      if (redir) begin
        seg_q <= new_seg;
        off_q <= new_off;
        if (busy_q && !ack) drop_q <= 1'b1;
      end else if (!busy_q && (free >= NEED)) begin
        busy_q <= 1'b1;
        addr_q <= phys_addr(seg_q, off_q);
      end
    end
  end

  always_comb begin
    req     = busy_q;
    addr    = addr_q;
    push_n  = accept ? take_n : 2'd0;
    push_d0 = lane0;
    push_d1 = lane1;
    seg_o   = seg_q;
    drop_o  = drop_q;
  end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int          BUS_W   = 16,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redir_i,
  input  logic [15:0]      redir_seg_i,
  input  logic [15:0]      redir_off_i,
  output logic             mem_req_o,
  output logic [19:0]      mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [BUS_W-1:0] mem_rdata_i,
  output logic             q_valid_o,
  output logic [7:0]       q_byte_o,
  input  logic             q_pop_i
);
  localparam int DEPTH = queue_depth(BUS_W);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] q_count, q_free;
  logic [1:0]       push_n;
  logic [7:0]       push_d0, push_d1;
  logic [15:0]      cur_seg;
  logic             drop_pend;

  pfq_fetch #(
    .BUS_W  (BUS_W),
    .CNT_W  (CNT_W),
    .RST_SEG(RST_SEG),
    .RST_OFF(RST_OFF)
  ) fetch_i (
    .clk    (clk),
    .rst    (rst),
    .redir  (redir_i),
    .new_seg(redir_seg_i),
    .new_off(redir_off_i),
    .free   (q_free),
    .ack    (mem_ack_i),
    .rdata  (mem_rdata_i),
    .req    (mem_req_o),
    .addr   (mem_addr_o),
    .push_n (push_n),
    .push_d0(push_d0),
    .push_d1(push_d1),
    .seg_o  (cur_seg),
    .drop_o (drop_pend)
  );

  pfq_fifo #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) fifo_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (redir_i),
    .push_n (push_n),
    .push_d0(push_d0),
    .push_d1(push_d1),
    .pop    (q_pop_i),
    .valid  (q_valid_o),
    .head   (q_byte_o),
    .count  (q_count),
    .free   (q_free)
  );

endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int LANES = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             redir,
  input logic             req,
  input logic [19:0]      addr,
  input logic             ack,
  input logic             valid,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] free,
  input logic             drop,
  input logic [15:0]      seg
);
  // R8: pending request and its address hold until acknowledged
  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(addr)));

  // R2: occupancy never beyond the queue depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R3: a new request only starts with enough free room
  a_r3_room_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> ($past(free) >= CNT_W'(LANES)));

  // R7: redirect leaves the queue empty
  a_r7_redirect_empties: assert property (@(posedge clk) disable iff (rst)
    redir |=> !valid);

  // R9: empty queue stays empty without an acknowledge, whatever the pop
  a_r9_empty_stays: assert property (@(posedge clk) disable iff (rst)
    (!valid && !ack) |=> !valid);

  // R8: data returning for a discarded fetch adds nothing
  a_r8_drop_no_push: assert property (@(posedge clk) disable iff (rst)
    (ack && drop && !redir) |=> (count <= $past(count)));

  // R10: segment only changes on redirect
  a_r10_segment_kept: assert property (@(posedge clk) disable iff (rst)
    !redir |=> $stable(seg));

endmodule

bind prefetch_queue prefetch_queue_chk #(
  .DEPTH(DEPTH),
  .LANES(BUS_W / 8),
  .CNT_W(CNT_W)
) chk_i (
  .clk  (clk),
  .rst  (rst),
  .redir(redir_i),
  .req  (mem_req_o),
  .addr (mem_addr_o),
  .ack  (mem_ack_i),
  .valid(q_valid_o),
  .count(q_count),
  .free (q_free),
  .drop (drop_pend),
  .seg  (cur_seg)
);

// File: tb/prefetch_queue_tb_top.sv
`timescale 1ns/1ps
module prefetch_queue_tb_top;
  import pfq_pkg::*;

  localparam int BUS_W = 16;
  localparam int LANES = BUS_W / 8;
  localparam int DEPTH = queue_depth(BUS_W);
  localparam int NVEC  = 6;
  // {segment, offset, bytes to consume}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h24F6, 16'h634A, 16'd12},  // R1 even start
    {16'h1000, 16'h0007, 16'd9},   // R4 odd start realigns
    {16'h0100, 16'hFFFC, 16'd10},  // R10 offset wrap
    {16'hF000, 16'hFFFF, 16'd6},   // R10 odd start at wrap point
    {16'hFFFF, 16'h0010, 16'd8},   // R1 20-bit address wrap
    {16'h0000, 16'h0000, 16'd16}   // R5 long stream
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             redir_i = 1'b0;
  logic [15:0]      redir_seg_i = '0;
  logic [15:0]      redir_off_i = '0;
  logic             mem_req_o;
  logic [19:0]      mem_addr_o;
  logic             mem_ack_i = 1'b0;
  logic [BUS_W-1:0] mem_rdata_i = '0;
  logic             q_valid_o;
  logic [7:0]       q_byte_o;
  logic             q_pop_i = 1'b0;
  logic             stall = 1'b0;
  int               checks = 0;
  int               fails = 0;

  always #2.5 clk = ~clk;

  prefetch_queue #(.BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .redir_i(redir_i), .redir_seg_i(redir_seg_i),
    .redir_off_i(redir_off_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .q_valid_o(q_valid_o),
    .q_byte_o(q_byte_o), .q_pop_i(q_pop_i)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    if (LANES == 2) return {mem_byte(a | 20'h1), mem_byte(a & ~20'h1)};
    return {8'h00, mem_byte(a)};
  endfunction

  // memory responder: acknowledge one negedge after seeing a request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o && !stall && !rst) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = BUS_W'(mem_word(mem_addr_o));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!mem_req_o) break;
    end
  endtask

  task automatic do_redirect(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk);
    redir_i = 1'b1; redir_seg_i = s; redir_off_i = o;
    @(negedge clk);
    redir_i = 1'b0;
    chk(!q_valid_o, "R7 queue empty after redirect", int'(q_valid_o), 0);
  endtask

  task automatic expect_req(input logic [19:0] a, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (mem_req_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen && mem_addr_o == a, tag, int'(mem_addr_o), int'(a));
  endtask

  task automatic drain(input logic [15:0] s, input logic [15:0] o,
                       input int n, input string tag);
    int k = 0;
    int guard = 0;
    while (k < n && guard < 400) begin
      @(negedge clk);
      guard++;
      if (q_valid_o) begin
        chk(q_byte_o == mem_byte(phys_addr(s, o + 16'(k))), tag,
            int'(q_byte_o), int'(mem_byte(phys_addr(s, o + 16'(k)))));
        q_pop_i = 1'b1;
        k++;
      end else q_pop_i = 1'b0;
    end
    @(negedge clk);
    q_pop_i = 1'b0;
    chk(k == n, {tag, " byte count"}, k, n);
  endtask

  task automatic count_held(input logic [15:0] s, input logic [15:0] o, output int cnt);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (q_valid_o) begin
        chk(q_byte_o == mem_byte(phys_addr(s, o + 16'(cnt))), "R5 held order",
            int'(q_byte_o), int'(mem_byte(phys_addr(s, o + 16'(cnt)))));
        q_pop_i = 1'b1;
        cnt++;
      end else begin
        q_pop_i = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int held;
    // R11 reset state
    repeat (4) @(negedge clk);
    chk(!mem_req_o, "R11 no request in reset", int'(mem_req_o), 0);
    chk(!q_valid_o, "R11 queue empty in reset", int'(q_valid_o), 0);
    rst = 1'b0;
    expect_req(20'hFFFF0, "R11 first fetch address");

    // vector table: redirect, check address, consume stream in order
    for (int i = 0; i < NVEC; i++) begin
      wait_idle();
      do_redirect(VEC[i][47:32], VEC[i][31:16]);
      expect_req(phys_addr(VEC[i][47:32], VEC[i][31:16]), "R1 redirect address");
      drain(VEC[i][47:32], VEC[i][31:16], int'(VEC[i][15:0]), "R4 R5 R10 stream");
    end

    // R6 / R2: fill without popping, then count held bytes
    wait_idle();
    do_redirect(16'h3000, 16'h0010);
    repeat (40) @(negedge clk);
    chk(!mem_req_o, "R6 no request when full", int'(mem_req_o), 0);
    stall = 1'b1;
    count_held(16'h3000, 16'h0010, held);
    chk(held == DEPTH, "R2 depth of full queue", held, DEPTH);
    // R9: popping an empty queue changes nothing
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      q_pop_i = 1'b1;
      chk(!q_valid_o, "R9 empty stays invalid", int'(q_valid_o), 0);
    end
    @(negedge clk);
    q_pop_i = 1'b0;
    stall = 1'b0;

    // R3: odd start leaves one free byte on the wide bus, no request
    wait_idle();
    do_redirect(16'h3000, 16'h0011);
    repeat (40) @(negedge clk);
    chk(!mem_req_o, "R3 no request with too little room", int'(mem_req_o), 0);
    drain(16'h3000, 16'h0011, 1, "R3 first byte");
    expect_req(phys_addr(16'h3000, 16'h0011 + 16'((LANES == 2) ? DEPTH - 1 : DEPTH)),
               "R3 request after room frees");
    drain(16'h3000, 16'h0012, 8, "R4 stream after refill");

    // R8: redirect while a fetch is outstanding
    wait_idle();
    stall = 1'b1;
    do_redirect(16'h5000, 16'h0100);
    expect_req(20'h50100, "R1 stalled fetch address");
    @(negedge clk);
    redir_i = 1'b1; redir_seg_i = 16'h6000; redir_off_i = 16'h0200;
    @(negedge clk);
    redir_i = 1'b0;
    chk(mem_req_o && mem_addr_o == 20'h50100, "R8 request held over redirect",
        int'(mem_addr_o), 32'h50100);
    stall = 1'b0;
    wait_idle();
    expect_req(20'h60200, "R7 restart at new address");
    drain(16'h6000, 16'h0200, 8, "R8 stale data discarded");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule